// File: doc/BRIEF.md
# Half-Duplex Framed Request Engine with Reply Timeout and Retry

This block runs one request/reply transaction at a time with a remote unit over a half-duplex RS485 byte link. When software logic raises a one-cycle request strobe while the engine is idle, the engine captures a 26-byte request payload. It builds a fixed 28-byte frame from a start delimiter, the payload and a trailing CRC-8. It hands the frame one byte at a time to an external UART transmitter and holds the line-driver enable high for the whole transmission.

Once the transmitter has gone idle after the last byte, the engine releases the driver and listens on the UART receive byte stream. It hunts for the delimiter, collects a full frame and checks its CRC. A good reply ends the transaction with a one-cycle reply-valid pulse and the reply payload. A frame that fails its CRC is dropped, and the engine keeps listening in the same window.

If no good reply arrives within the listening window (100000 clocks by default, 2 ms at 50 MHz), the engine sends the same frame again. It does this up to two more times. After the last allowed attempt also times out, it pulses an error flag and returns to idle.

Top module: `rs485_req_engine`

## Requirements
- R1: While reset is active and in the first cycles after it is released, `tx_valid_o`, `tx_en_o`, `rsp_valid_o` and `err_o` are all low.
- R2: Each transmitted frame has `FRAME_BYTES` (28) bytes. Byte 0 is 0x40. Byte k, for 1 <= k <= 26, is `req_payload_i[8*(k-1) +: 8]` as captured when the request was accepted.
- R3: Byte 27 of a transmitted frame is a CRC-8 over bytes 0 to 26. The polynomial is 0x07, the register starts at 0xFF, each byte enters MSB first, and no final XOR is applied.
- R4: `tx_en_o` is high from the cycle the first byte is offered until `tx_idle_i` is seen high after the last byte was accepted. It is low while the engine listens. `tx_valid_o` is never high without `tx_en_o`, and an offered byte stays unchanged until `tx_ready_i` takes it.
- R5: If no good reply arrives, `tx_en_o` stays low for exactly `TIMEOUT_CYC` cycles after a frame ends. The identical frame is then sent again.
- R6: At most `MAX_RETRY` (2) resends follow the first frame. When the last one times out, `err_o` pulses for one cycle, no further frame is sent, and the engine returns to idle.
- R7: A reply that starts with 0x40 and carries a matching CRC-8 (as in R3) in byte 27 ends the transaction with a one-cycle `rsp_valid_o` pulse. `rsp_payload_o[8*(k-1) +: 8]` then holds reply byte k for 1 <= k <= 26, and no further frame is sent.
- R8: A reply whose byte 27 does not match its CRC gives no `rsp_valid_o`. The listening window keeps running, so a good reply later in the same window is still accepted, and otherwise the window times out as in R5.
- R9: While the engine hunts for a reply, received bytes other than 0x40 are ignored.
- R10: `req_i` is ignored while a transaction is in progress. It is not queued, and it does not change the payload of the frames being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle request strobe, taken only when idle |
| req_payload_i | input | 208 | Request payload, byte k-1 of the payload goes to frame byte k |
| tx_data_o | output | 8 | Byte offered to the UART transmitter |
| tx_valid_o | output | 1 | `tx_data_o` is valid |
| tx_ready_i | input | 1 | UART transmitter takes the offered byte this cycle |
| tx_idle_i | input | 1 | UART transmitter has finished shifting out all bytes |
| tx_en_o | output | 1 | RS485 line-driver enable |
| rx_data_i | input | 8 | Byte from the UART receiver |
| rx_valid_i | input | 1 | `rx_data_i` is valid this cycle |
| rsp_valid_o | output | 1 | One-cycle pulse: a good reply was received |
| rsp_payload_o | output | 208 | Payload of the last good reply, bytes 1 to 26 |
| err_o | output | 1 | One-cycle pulse: all attempts timed out |

## Verification
Each transaction is driven by a remote-unit model that replies in a different way. It may send a clean reply, noise bytes before a clean reply, or a corrupted reply followed by a clean one in the same window. It may also stay silent for one attempt and answer the next, stay silent on all attempts, or corrupt every reply. A clean reply shows that the CRC and payload mapping agree. A noise prefix separates delimiter hunting from plain collection. A corrupted-then-clean reply shows that a bad frame is dropped without ending the window. The silent and always-corrupt cases count the attempts, measure the exact listening window, and show that the error pulse comes after the last permitted retry. Every transaction also carries a second request strobe with a changed payload in the middle of sending, and each frame is compared byte for byte against the captured payload.

// File: rtl/rs485_req_pkg.sv
package rs485_req_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_SEND,
      ENG_WAIT
   } eng_state_e;

   typedef enum logic [1:0] {
      TXF_IDLE,
      TXF_SEND,
      TXF_DRAIN
   } txf_state_e;
endpackage

// File: rtl/rs485_crc8_byte.sv
// One byte through an MSB-first CRC-8 register, unrolled bit by bit.
module rs485_crc8_byte #(
   parameter logic [7:0] POLY = 8'h07
) (
   input  logic [7:0] crc_i,
   input  logic [7:0] data_i,
   output logic [7:0] crc_o
);
   logic [8:0][7:0] stage;

   assign stage[0] = crc_i;

   for (genvar b = 0; b < 8; b++) begin : g_bit
      logic fb;
      assign fb           = stage[b][7] ^ data_i[7-b];
      assign stage[b + 1] = {stage[b][6:0], 1'b0} ^ (fb ? POLY : 8'h00);
   end

   assign crc_o = stage[8];
endmodule

// File: rtl/rs485_tx_framer.sv
// Walks a frame out byte by byte: delimiter, payload, running CRC.
module rs485_tx_framer
   import rs485_req_pkg::*;
#(
   parameter int unsigned FRAME_BYTES = 28,
   parameter logic [7:0]  DELIM       = 8'h40,
   parameter logic [7:0]  CRC_POLY    = 8'h07,
   parameter logic [7:0]  CRC_INIT    = 8'hFF
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start_i,
   input  logic [BYTE_W*(FRAME_BYTES-2)-1:0] payload_i,
   output logic [7:0]                       tx_data_o,
   output logic                             tx_valid_o,
   input  logic                             tx_ready_i,
   input  logic                             tx_idle_i,
   output logic                             tx_en_o,
   output logic                             done_o
);
   localparam int unsigned IDX_W = $clog2(FRAME_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

   if (FRAME_BYTES < 3) begin : g_chk_frame
      $error("rs485_tx_framer: FRAME_BYTES must be at least 3");
   end

   txf_state_e       st_q;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]       crc_q;
   logic [7:0]       crc_nxt;
   logic [7:0]       cur_byte;

   always_comb begin
      if (idx_q == '0) begin
         cur_byte = DELIM;
      end else if (idx_q == LAST_IDX) begin
         cur_byte = crc_q;
      end else begin
         cur_byte = payload_i[BYTE_W*(int'(idx_q) - 1) +: BYTE_W];
      end
   end

   rs485_crc8_byte #(.POLY(CRC_POLY)) i_crc (
      .crc_i (crc_q),
      .data_i(cur_byte),
      .crc_o (crc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TXF_IDLE;
         idx_q <= '0;
         crc_q <= CRC_INIT;
      end else begin
         case (st_q)
            TXF_IDLE: begin
               if (start_i) begin
                  st_q  <= TXF_SEND;
                  idx_q <= '0;
                  crc_q <= CRC_INIT;
               end
            end
            TXF_SEND: begin
               if (tx_ready_i) begin
                  crc_q <= crc_nxt;
                  if (idx_q == LAST_IDX) begin
                     st_q <= TXF_DRAIN;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            TXF_DRAIN: begin
               if (tx_idle_i) begin
                  st_q <= TXF_IDLE;
               end
            end
            default: st_q <= TXF_IDLE;
         endcase
      end
   end

   assign tx_data_o  = cur_byte;
   assign tx_valid_o = (st_q == TXF_SEND);
   assign tx_en_o    = (st_q != TXF_IDLE);
   assign done_o     = (st_q == TXF_DRAIN) && tx_idle_i;

   assert_first_byte_delim_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid_o) |-> tx_data_o == DELIM);

   assert_hold_offered_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

   assert_enable_until_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en_o && !tx_valid_o && !tx_idle_i) |=> tx_en_o);
endmodule

// File: rtl/rs485_rx_framer.sv
// Hunts for the delimiter, collects a frame, checks its CRC.
module rs485_rx_framer
   import rs485_req_pkg::*;
#(
   parameter int unsigned FRAME_BYTES = 28,
   parameter logic [7:0]  DELIM       = 8'h40,
   parameter logic [7:0]  CRC_POLY    = 8'h07,
   parameter logic [7:0]  CRC_INIT    = 8'hFF
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             listen_i,
   input  logic [7:0]                       rx_data_i,
   input  logic                             rx_valid_i,
   output logic                             frame_ok_o,
   output logic                             frame_bad_o,
   output logic [BYTE_W*(FRAME_BYTES-2)-1:0] payload_o
);
   localparam int unsigned IDX_W = $clog2(FRAME_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);
   localparam int unsigned PAY_W = BYTE_W * (FRAME_BYTES - 2);

   if (FRAME_BYTES < 3) begin : g_chk_frame
      $error("rs485_rx_framer: FRAME_BYTES must be at least 3");
   end

   logic [IDX_W-1:0] cnt_q;
   logic [7:0]       crc_q;
   logic [7:0]       crc_in;
   logic [7:0]       crc_nxt;
   logic [PAY_W-1:0] pay_q;
   logic             ok_q;
   logic             bad_q;

   assign crc_in = (cnt_q == '0) ? CRC_INIT : crc_q;

   rs485_crc8_byte #(.POLY(CRC_POLY)) i_crc (
      .crc_i (crc_in),
      .data_i(rx_data_i),
      .crc_o (crc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         crc_q <= CRC_INIT;
         pay_q <= '0;
         ok_q  <= 1'b0;
         bad_q <= 1'b0;
      end else begin
         ok_q  <= 1'b0;
         bad_q <= 1'b0;
         if (!listen_i) begin
            cnt_q <= '0;
         end else if (rx_valid_i) begin
            if (cnt_q == '0) begin
               if (rx_data_i == DELIM) begin
                  cnt_q <= IDX_W'(1);
                  crc_q <= crc_nxt;
               end
            end else if (cnt_q == LAST_IDX) begin
               cnt_q <= '0;
               if (rx_data_i == crc_q) begin
                  ok_q <= 1'b1;
               end else begin
                  bad_q <= 1'b1;
               end
            end else begin
               pay_q[BYTE_W*(int'(cnt_q) - 1) +: BYTE_W] <= rx_data_i;
               crc_q <= crc_nxt;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign frame_ok_o  = ok_q;
   assign frame_bad_o = bad_q;
   assign payload_o   = pay_q;

   assert_hunt_drops_noise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (listen_i && rx_valid_i && cnt_q == '0 && rx_data_i != DELIM) |=> (cnt_q == '0 && !frame_ok_o));

   assert_ok_only_when_listening_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok_o |-> $past(listen_i && rx_valid_i));

   assert_ok_bad_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_ok_o && frame_bad_o));
endmodule

// File: rtl/rs485_reply_timer.sv
// Counts the listening window; restarts whenever run_i drops.
module rs485_reply_timer #(
   parameter int unsigned TIMEOUT_CYC = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);
   localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(TIMEOUT_CYC - 1);

   if (TIMEOUT_CYC < 2) begin : g_chk_timeout
      $error("rs485_reply_timer: TIMEOUT_CYC must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST_CNT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired_o = run_i && (cnt_q == LAST_CNT);

   assert_expire_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      expired_o |-> $past(run_i));
endmodule

// File: rtl/rs485_req_engine.sv
// Request/reply transaction engine with bounded retry.
module rs485_req_engine
   import rs485_req_pkg::*;
#(
   parameter int unsigned FRAME_BYTES = 28,
   parameter logic [7:0]  DELIM       = 8'h40,
   parameter logic [7:0]  CRC_POLY    = 8'h07,
   parameter logic [7:0]  CRC_INIT    = 8'hFF,
   parameter int unsigned TIMEOUT_CYC = 100000,
   parameter int unsigned MAX_RETRY   = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_i,
   input  logic [8*(FRAME_BYTES-2)-1:0] req_payload_i,
   output logic [7:0]                  tx_data_o,
   output logic                        tx_valid_o,
   input  logic                        tx_ready_i,
   input  logic                        tx_idle_i,
   output logic                        tx_en_o,
   input  logic [7:0]                  rx_data_i,
   input  logic                        rx_valid_i,
   output logic                        rsp_valid_o,
   output logic [8*(FRAME_BYTES-2)-1:0] rsp_payload_o,
   output logic                        err_o
);
   localparam int unsigned PAY_W = BYTE_W * (FRAME_BYTES - 2);
   localparam int unsigned RW    = $clog2(MAX_RETRY + 2);
   localparam logic [RW-1:0] RETRY_LIMIT = RW'(MAX_RETRY);

   if (MAX_RETRY > 255) begin : g_chk_retry
      $error("rs485_req_engine: MAX_RETRY out of range");
   end

   eng_state_e      st_q;
   logic [RW-1:0]   retry_q;
   logic [PAY_W-1:0] req_q;
   logic [PAY_W-1:0] rsp_q;
   logic [PAY_W-1:0] rx_pay;
   logic            rsp_valid_q;
   logic            err_q;
   logic            listen;
   logic            retry_left;
   logic            tx_start;
   logic            tx_done;
   logic            rx_ok;
   logic            rx_bad;
   logic            tmo;

   assign listen     = (st_q == ENG_WAIT);
   assign retry_left = (retry_q != RETRY_LIMIT);
   assign tx_start   = ((st_q == ENG_IDLE) && req_i) ||
                       (listen && tmo && !rx_ok && retry_left);

   rs485_tx_framer #(
      .FRAME_BYTES(FRAME_BYTES), .DELIM(DELIM),
      .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)
   ) i_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (tx_start),
      .payload_i (req_q),
      .tx_data_o (tx_data_o),
      .tx_valid_o(tx_valid_o),
      .tx_ready_i(tx_ready_i),
      .tx_idle_i (tx_idle_i),
      .tx_en_o   (tx_en_o),
      .done_o    (tx_done)
   );

   rs485_rx_framer #(
      .FRAME_BYTES(FRAME_BYTES), .DELIM(DELIM),
      .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)
   ) i_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .listen_i   (listen),
      .rx_data_i  (rx_data_i),
      .rx_valid_i (rx_valid_i),
      .frame_ok_o (rx_ok),
      .frame_bad_o(rx_bad),
      .payload_o  (rx_pay)
   );

   rs485_reply_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (listen),
      .expired_o(tmo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ENG_IDLE;
         retry_q     <= '0;
         req_q       <= '0;
         rsp_q       <= '0;
         rsp_valid_q <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         rsp_valid_q <= 1'b0;
         err_q       <= 1'b0;
         case (st_q)
            ENG_IDLE: begin
               if (req_i) begin
                  req_q   <= req_payload_i;
                  retry_q <= '0;
                  st_q    <= ENG_SEND;
               end
            end
            ENG_SEND: begin
               if (tx_done) begin
                  st_q <= ENG_WAIT;
               end
            end
            ENG_WAIT: begin
               if (rx_ok) begin
                  rsp_q       <= rx_pay;
                  rsp_valid_q <= 1'b1;
                  st_q        <= ENG_IDLE;
               end else if (tmo) begin
                  if (retry_left) begin
                     retry_q <= retry_q + 1'b1;
                     st_q    <= ENG_SEND;
                  end else begin
                     err_q <= 1'b1;
                     st_q  <= ENG_IDLE;
                  end
               end
            end
            default: st_q <= ENG_IDLE;
         endcase
      end
   end

   assign rsp_valid_o   = rsp_valid_q;
   assign rsp_payload_o = rsp_q;
   assign err_o         = err_q;

   // Window length tracked by an independent counter for the R5 check.
   int unsigned wait_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_cnt_q <= 0;
      end else if (listen) begin
         wait_cnt_q <= wait_cnt_q + 1;
      end else begin
         wait_cnt_q <= 0;
      end
   end

   assert_full_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (listen && tmo) |-> (wait_cnt_q == TIMEOUT_CYC - 1));

   assert_quiet_while_listening_R4: assert property (@(posedge clk) disable iff (!rst_n)
      listen |-> !tx_en_o);

   assert_err_after_last_try_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ($past(retry_q) == RETRY_LIMIT));

   assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_valid_o, err_o}));

   assert_rsp_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |=> !rsp_valid_o);

   assert_rsp_from_good_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> $past(rx_ok));

   assert_bad_frame_no_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_bad |=> !rsp_valid_o);

   assert_busy_keeps_payload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ENG_IDLE) |=> $stable(req_q));
endmodule

// File: tb/test_rs485_req_engine.sv
module test_rs485_req_engine;
   localparam int FB   = 28;
   localparam int PB   = FB - 2;
   localparam int PW   = 8 * PB;
   localparam int TMO  = 300;
   localparam int NVEC = 7;
   // {seed, reply mode, expected frames, expected ok}
   // modes: 0 clean, 1 noise+clean, 2 bad/silent/clean, 3 silent, 4 always bad, 5 bad+clean
   localparam logic [31:0] VEC [NVEC] = '{
      32'h11_00_01_01, 32'hA7_01_01_01, 32'h3C_02_03_01, 32'h00_03_03_00,
      32'hFF_04_03_00, 32'h5E_05_01_01, 32'h40_00_01_01
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [PW-1:0] req_payload = '0;
   logic [7:0]    tx_data;
   logic          tx_valid;
   logic          tx_ready;
   logic          tx_idle;
   logic          tx_en;
   logic [7:0]    rx_data = 8'h00;
   logic          rx_valid = 1'b0;
   logic          rsp_valid;
   logic [PW-1:0] rsp_payload;
   logic          err;

   always #4 clk = ~clk;

   rs485_req_engine #(.TIMEOUT_CYC(TMO)) i_rs485_req_engine (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_payload_i(req_payload),
      .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
      .tx_idle_i(tx_idle), .tx_en_o(tx_en), .rx_data_i(rx_data),
      .rx_valid_i(rx_valid), .rsp_valid_o(rsp_valid),
      .rsp_payload_o(rsp_payload), .err_o(err)
   );

   // UART transmitter model: busy for 3 cycles per byte
   int busy = 0;
   assign tx_ready = (busy == 0);
   assign tx_idle  = (busy == 0);
   always @(posedge clk) begin
      if (tx_valid && tx_ready) busy <= 3;
      else if (busy > 0) busy <= busy - 1;
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_crc(input logic [7:0] f [FB]);
      logic [7:0] c = 8'hFF;
      for (int k = 0; k < FB - 1; k++) begin
         c ^= f[k];
         for (int b = 0; b < 8; b++) c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
      end
      return c;
   endfunction

   // Monitor, sampled at the falling edge
   logic [7:0]    exp_tx [FB];
   int            bidx = 0;
   int            frames = 0;
   int            low_cnt = 0;
   int            rsp_cnt = 0;
   int            err_cnt = 0;
   logic [PW-1:0] last_rsp = '0;
   logic          prev_en = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid && !tx_en) chk(1'b0, "R4", "valid without enable", 1, 0);
         if (tx_valid && tx_ready) begin
            if (bidx < FB)
               chk(tx_data == exp_tx[bidx], (bidx == FB - 1) ? "R3" : "R2",
                   $sformatf("frame byte %0d", bidx), PW'(tx_data), PW'(exp_tx[bidx]));
            bidx++;
         end
         if (prev_en && !tx_en) begin
            frames++;
            chk(bidx == FB, "R4", "bytes per frame", PW'(bidx), PW'(FB));
            chk(busy == 0, "R4", "enable dropped before UART idle", PW'(busy), 0);
            bidx = 0;
         end
         if (!prev_en && tx_en && frames > 0)
            chk(low_cnt == TMO, "R5", "listen window length", PW'(low_cnt), PW'(TMO));
         if (tx_en) low_cnt = 0;
         else low_cnt++;
         if (rsp_valid) begin
            rsp_cnt++;
            last_rsp = rsp_payload;
         end
         if (err) err_cnt++;
         prev_en = tx_en;
      end
   end

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_data  = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic send_reply(input logic [7:0] seed, input bit corrupt,
                             output logic [PW-1:0] pay);
      logic [7:0] rep [FB];
      rep[0] = 8'h40;
      for (int k = 1; k < FB - 1; k++) rep[k] = (seed + 8'(k * 5)) ^ 8'h3C;
      rep[FB-1] = ref_crc(rep) ^ (corrupt ? 8'h01 : 8'h00);
      for (int k = 1; k < FB - 1; k++) pay[8*(k-1) +: 8] = rep[k];
      for (int k = 0; k < FB; k++) send_byte(rep[k]);
   endtask

   // reply kinds: 0 none, 1 clean, 2 bad, 3 noise+clean, 4 bad+clean
   function automatic int reply_kind(input int mode, input int f);
      case (mode)
         0: return (f == 0) ? 1 : 0;
         1: return (f == 0) ? 3 : 0;
         2: return (f == 0) ? 2 : ((f == 2) ? 1 : 0);
         4: return 2;
         5: return (f == 0) ? 4 : 0;
         default: return 0;
      endcase
   endfunction

   task automatic run_case(input int id, input logic [7:0] seed, input int mode,
                           input int exp_frames, input bit exp_ok);
      logic [PW-1:0] pay;
      logic [PW-1:0] exp_rsp = '0;
      logic [PW-1:0] junk;
      int guard;
      @(posedge clk);
      frames = 0; rsp_cnt = 0; err_cnt = 0; bidx = 0;
      exp_tx[0] = 8'h40;
      for (int k = 1; k < FB - 1; k++) begin
         exp_tx[k] = seed * 8'd3 + 8'(k * 11);
         pay[8*(k-1) +: 8] = exp_tx[k];
      end
      exp_tx[FB-1] = ref_crc(exp_tx);
      @(negedge clk);
      req_payload = pay;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      // R10: a second strobe with another payload while sending
      repeat (5) @(negedge clk);
      req_payload = ~pay;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      for (int f = 0; f < exp_frames; f++) begin
         guard = 0;
         while (frames < f + 1 && guard < 4 * TMO) begin
            @(posedge clk);
            guard++;
         end
         chk(frames >= f + 1, "R5", $sformatf("case %0d frame %0d sent", id, f),
             PW'(frames), PW'(f + 1));
         case (reply_kind(mode, f))
            1: send_reply(seed ^ 8'h5A, 1'b0, exp_rsp);
            2: send_reply(seed ^ 8'h5A, 1'b1, junk);
            3: begin
               send_byte(8'h11); send_byte(8'h3F); send_byte(8'hC0);  // R9 noise
               send_reply(seed ^ 8'h5A, 1'b0, exp_rsp);
            end
            4: begin
               send_reply(seed ^ 8'h5A, 1'b1, junk);               // R8 dropped
               send_reply(seed ^ 8'hA5, 1'b0, exp_rsp);
            end
            default: ;
         endcase
      end
      guard = 0;
      while (rsp_cnt + err_cnt == 0 && guard < 4 * TMO) begin
         @(posedge clk);
         guard++;
      end
      repeat (TMO + 40) @(posedge clk);
      chk(frames == exp_frames, exp_ok ? "R10" : "R6", $sformatf("case %0d frame count", id),
          PW'(frames), PW'(exp_frames));
      chk(rsp_cnt == int'(exp_ok), "R7", $sformatf("case %0d reply pulses", id),
          PW'(rsp_cnt), PW'(exp_ok));
      chk(err_cnt == int'(!exp_ok), "R6", $sformatf("case %0d error pulses", id),
          PW'(err_cnt), PW'(!exp_ok));
      if (exp_ok)
         chk(last_rsp == exp_rsp, (mode == 1) ? "R9" : ((mode == 5) ? "R8" : "R7"),
             $sformatf("case %0d reply payload", id), last_rsp, exp_rsp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R6 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({tx_valid, tx_en, rsp_valid, err} == 4'b0, "R1", "outputs in reset",
          PW'({tx_valid, tx_en, rsp_valid, err}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({tx_valid, tx_en, rsp_valid, err} == 4'b0, "R1", "outputs after reset",
          PW'({tx_valid, tx_en, rsp_valid, err}), 0);
      for (int v = 0; v < NVEC; v++)
         run_case(v, VEC[v][31:24], int'(VEC[v][23:16]), int'(VEC[v][15:8]), VEC[v][0]);
      // R9: noise while idle starts nothing
      send_byte(8'h40); send_byte(8'h12);
      repeat (20) @(negedge clk);
      chk({tx_en, rsp_valid, err} == 3'b0 && rsp_cnt == 1, "R9", "idle noise ignored",
          PW'({tx_en, rsp_valid, err}), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule